// File: doc/BRIEF.md
# Interval Timer Host Register Interface

This block is the byte-wide host side of a three-channel interval timer. A host reads and writes single bytes through a 2-bit address. Addresses 0, 1 and 2 reach the data port of one channel each, and address 3 takes control words. The block decodes each control word into a per-channel configuration: access width, counting mode and decimal flag. That configuration is presented to the counting engine, which lies outside this block.

Data bytes written to a channel are assembled into a 16-bit reload value. The value is handed to the engine with a one-cycle load strobe. Reads return either the engine's live count or a snapshot taken by a latch command. Snapshots come from a single-channel counter-latch command or from a multi-channel read-back command, and a read-back can also capture a status byte. Read data is combinational on the current address. A read strobe consumes the byte at the next clock edge.

Top module: `tmr_host_if`

## Requirements
- R1: A read at address 3 returns 0x00. Addresses 0, 1 and 2 read and write channels 0, 1 and 2.
- R2: A control write (address 3) whose bits 7:6 name channel 0..2 and whose bits 5:4 are nonzero stores bits 5:4 as that channel's access field, bits 3:1 as its mode and bit 0 as its decimal flag, all visible on the configuration ports the cycle after the write. Other channels keep their configuration.
- R3: In access 1 (low only) a data byte b loads 0x00b. In access 2 (high only) it loads b<<8. `ld_stb` for that channel only is high for the single cycle after the write edge, with the value on `ld_val`.
- R4: In access 3 (word) the first data byte is held without a load, and the second byte loads {second, first}.
- R5: A control write with nonzero access returns that channel's write and read byte sequencers to the low-byte step.
- R6: A control write with bits 5:4 = 0 snapshots that channel's live count. In word access the snapshot reads low byte then high byte; in low-only or high-only access a single read returns that byte. The snapshot is then released and reads return the live count again.
- R7: While a count snapshot or a status snapshot is pending on a channel, a further latch of the same kind leaves the held value unchanged.
- R8: A control write with bits 7:6 = 3 is a read-back. Bits 1, 2 and 3 select channels 0, 1 and 2. Bit 5 = 0 latches the count, and bit 4 = 0 latches a status byte {OUT, 0, access[1:0], mode[2:0], decimal}. Unselected channels are untouched.
- R9: A channel read returns a pending status byte first, then a pending count snapshot, and otherwise the live count.
- R10: Without a snapshot, word-access reads alternate low byte then high byte. Low-only and high-only reads always return the same half.
- R11: Each data port moves only its own channel's sequencers, and the read and write sequencers of a channel step independently of each other.
- R12: After reset every channel's access, mode and decimal fields are 0 and no load strobe is active. Access 0 then behaves as low-byte only for data reads and writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 2 | Register address |
| bus_wr | input | 1 | Byte write strobe |
| bus_rd | input | 1 | Byte read strobe; consumes the byte at the clock edge |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the addressed port (combinational) |
| ld_stb | output | NCH | Per-channel reload strobe |
| ld_val | output | NCH*16 | Per-channel reload value |
| ch_mode | output | NCH*3 | Per-channel counting mode |
| ch_acc | output | NCH*2 | Per-channel access field |
| ch_bcd | output | NCH | Per-channel decimal flag |
| cnt_live | input | NCH*16 | Live count from the counting engine, per channel |
| out_lvl | input | NCH | OUT level from the counting engine, per channel |

## Verification
A wrong byte-sequencer state shows up at the next data access to that channel. A load fires one byte early or late, or a read returns the opposite half. A stuck or lost pending flag is seen on the first read after the latch command: the frozen value is missing, or the live value is replaced by a stale one. The stimulus therefore changes the live count between a latch and its reads, and it interleaves ports and strobe types so that a sequencer shared or crossed between channels, or between read and write, gives a different byte within one or two accesses.

// File: rtl/tmr_regs_pkg.sv
package tmr_regs_pkg;

    localparam int BW     = 8;
    localparam int CW     = 2 * BW;
    localparam int MAX_CH = 3;

    typedef enum logic [1:0] {
        ACC_CMD  = 2'd0,
        ACC_LO   = 2'd1,
        ACC_HI   = 2'd2,
        ACC_WORD = 2'd3
    } acc_e;

    typedef struct packed {
        acc_e       acc;
        logic [2:0] mode;
        logic       bcd;
    } chan_cfg_t;

    typedef struct packed {
        logic      cfg_we;
        chan_cfg_t cfg;
        logic      cnt_latch;
        logic      sts_latch;
    } chan_cmd_t;

    function automatic logic [BW-1:0] status_byte(logic out, chan_cfg_t c);
        return {out, 1'b0, c.acc, c.mode, c.bcd};
    endfunction

    function automatic logic [BW-1:0] pick_byte(logic [CW-1:0] v, logic hi);
        return hi ? v[CW-1:BW] : v[BW-1:0];
    endfunction

endpackage

// File: rtl/tmr_ctl_decode.sv
module tmr_ctl_decode
    import tmr_regs_pkg::*;
#(
    parameter int NCH = 3
) (
    input  logic                 wr_en,
    input  logic [1:0]           addr,
    input  logic [BW-1:0]        wdata,
    output chan_cmd_t [NCH-1:0]  cmd_o
);

    localparam logic [1:0] CTL_ADDR = 2'd3;
    localparam logic [1:0] SEL_RB   = 2'd3;

    logic [1:0] sel;
    acc_e       acc_f;

    assign sel   = wdata[7:6];
    assign acc_f = acc_e'(wdata[5:4]);

    always_comb begin
        for (int i = 0; i < NCH; i++) begin
            cmd_o[i] = '0;
            if (wr_en && addr == CTL_ADDR) begin
                if (sel == SEL_RB) begin
                    if (wdata[1+i]) begin
                        cmd_o[i].cnt_latch = ~wdata[5];
                        cmd_o[i].sts_latch = ~wdata[4];
                    end
                end else if (sel == i[1:0]) begin
                    if (acc_f == ACC_CMD) begin
                        cmd_o[i].cnt_latch = 1'b1;
                    end else begin
                        cmd_o[i].cfg_we   = 1'b1;
                        cmd_o[i].cfg.acc  = acc_f;
                        cmd_o[i].cfg.mode = wdata[3:1];
                        cmd_o[i].cfg.bcd  = wdata[0];
                    end
                end
            end
        end
    end

endmodule

// File: rtl/tmr_chan_port.sv
module tmr_chan_port
    import tmr_regs_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    input  chan_cmd_t      cmd,
    input  logic           data_wr,
    input  logic           data_rd,
    input  logic [BW-1:0]  wdata,
    input  logic [CW-1:0]  live_cnt,
    input  logic           out_lvl,
    output chan_cfg_t      cfg_o,
    output logic [BW-1:0]  rd_byte_o,
    output logic           load_stb_o,
    output logic [CW-1:0]  load_val_o
);

    chan_cfg_t      cfg_q;
    logic           wr_hi_q;
    logic [BW-1:0]  hold_q;
    logic           rd_hi_q;
    logic           cnt_pend_q;
    acc_e           cnt_acc_q;
    logic [CW-1:0]  cnt_snap_q;
    logic           sts_pend_q;
    logic [BW-1:0]  sts_snap_q;

    assign cfg_o = cfg_q;

    // Read byte selection: status, then snapshot, then live count.
    always_comb begin
        if (sts_pend_q) begin
            rd_byte_o = sts_snap_q;
        end else if (cnt_pend_q) begin
            unique case (cnt_acc_q)
                ACC_HI:  rd_byte_o = pick_byte(cnt_snap_q, 1'b1);
                default: rd_byte_o = pick_byte(cnt_snap_q, 1'b0);
            endcase
        end else begin
            unique case (cfg_q.acc)
                ACC_HI:   rd_byte_o = pick_byte(live_cnt, 1'b1);
                ACC_WORD: rd_byte_o = pick_byte(live_cnt, rd_hi_q);
                default:  rd_byte_o = pick_byte(live_cnt, 1'b0);
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q      <= '0;
            wr_hi_q    <= 1'b0;
            hold_q     <= '0;
            rd_hi_q    <= 1'b0;
            cnt_pend_q <= 1'b0;
            cnt_acc_q  <= ACC_CMD;
            cnt_snap_q <= '0;
            sts_pend_q <= 1'b0;
            sts_snap_q <= '0;
            load_stb_o <= 1'b0;
            load_val_o <= '0;
        end else begin
            load_stb_o <= 1'b0;

            if (cmd.cfg_we) begin
                cfg_q   <= cmd.cfg;
                wr_hi_q <= 1'b0;
                rd_hi_q <= 1'b0;
            end else begin
                if (data_wr) begin
                    unique case (cfg_q.acc)
                        ACC_HI: begin
                            load_stb_o <= 1'b1;
                            load_val_o <= {wdata, {BW{1'b0}}};
                        end
                        ACC_WORD: begin
                            if (!wr_hi_q) begin
                                hold_q  <= wdata;
                                wr_hi_q <= 1'b1;
                            end else begin
                                load_stb_o <= 1'b1;
                                load_val_o <= {wdata, hold_q};
                                wr_hi_q    <= 1'b0;
                            end
                        end
                        default: begin
                            load_stb_o <= 1'b1;
                            load_val_o <= {{BW{1'b0}}, wdata};
                        end
                    endcase
                end
                if (data_rd && !sts_pend_q && !cnt_pend_q && cfg_q.acc == ACC_WORD) begin
                    rd_hi_q <= ~rd_hi_q;
                end
            end

            // Consumption of snapshots by a read.
            if (data_rd) begin
                if (sts_pend_q) begin
                    sts_pend_q <= 1'b0;
                end else if (cnt_pend_q) begin
                    if (cnt_acc_q == ACC_WORD) begin
                        cnt_acc_q <= ACC_HI;
                    end else begin
                        cnt_pend_q <= 1'b0;
                    end
                end
            end

            // Latch commands; a pending snapshot is kept.
            if (cmd.cnt_latch && !cnt_pend_q) begin
                cnt_pend_q <= 1'b1;
                cnt_snap_q <= live_cnt;
                cnt_acc_q  <= cfg_q.acc;
            end
            if (cmd.sts_latch && !sts_pend_q) begin
                sts_pend_q <= 1'b1;
                sts_snap_q <= status_byte(out_lvl, cfg_q);
            end
        end
    end

endmodule

// File: rtl/tmr_rd_mux.sv
module tmr_rd_mux
    import tmr_regs_pkg::*;
#(
    parameter int NCH = 3
) (
    input  logic [1:0]              addr,
    input  logic [NCH-1:0][BW-1:0]  ch_byte,
    output logic [BW-1:0]           rdata
);

    always_comb begin
        rdata = '0;
        for (int i = 0; i < NCH; i++) begin
            if (addr == i[1:0]) begin
                rdata = ch_byte[i];
            end
        end
    end

endmodule

// File: rtl/tmr_host_if.sv
module tmr_host_if
    import tmr_regs_pkg::*;
#(
    parameter int NCH = 3
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [1:0]           bus_addr,
    input  logic                 bus_wr,
    input  logic                 bus_rd,
    input  logic [7:0]           bus_wdata,
    output logic [7:0]           bus_rdata,
    output logic [NCH-1:0]       ld_stb,
    output logic [NCH*16-1:0]    ld_val,
    output logic [NCH*3-1:0]     ch_mode,
    output logic [NCH*2-1:0]     ch_acc,
    output logic [NCH-1:0]       ch_bcd,
    input  logic [NCH*16-1:0]    cnt_live,
    input  logic [NCH-1:0]       out_lvl
);

    chan_cmd_t [NCH-1:0]        cmd;
    logic      [NCH-1:0][BW-1:0] ch_byte;

    tmr_ctl_decode #(.NCH(NCH)) u_dec (
        .wr_en (bus_wr),
        .addr  (bus_addr),
        .wdata (bus_wdata),
        .cmd_o (cmd)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        chan_cfg_t cfg;
        logic      sel;

        assign sel = (bus_addr == g[1:0]);

        tmr_chan_port u_port (
            .clk        (clk),
            .rst        (rst),
            .cmd        (cmd[g]),
            .data_wr    (bus_wr & sel),
            .data_rd    (bus_rd & sel),
            .wdata      (bus_wdata),
            .live_cnt   (cnt_live[g*CW +: CW]),
            .out_lvl    (out_lvl[g]),
            .cfg_o      (cfg),
            .rd_byte_o  (ch_byte[g]),
            .load_stb_o (ld_stb[g]),
            .load_val_o (ld_val[g*CW +: CW])
        );

        assign ch_mode[g*3 +: 3] = cfg.mode;
        assign ch_acc[g*2 +: 2]  = cfg.acc;
        assign ch_bcd[g]         = cfg.bcd;
    end

    tmr_rd_mux #(.NCH(NCH)) u_mux (
        .addr    (bus_addr),
        .ch_byte (ch_byte),
        .rdata   (bus_rdata)
    );

endmodule

// File: rtl/tmr_host_if_chk.sv
module tmr_host_if_chk #(
    parameter int NCH = 3
) (
    input logic              clk,
    input logic              rst,
    input logic [1:0]        bus_addr,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [7:0]        bus_rdata,
    input logic [NCH-1:0]    ld_stb,
    input logic [NCH*3-1:0]  ch_mode,
    input logic [NCH*2-1:0]  ch_acc,
    input logic [NCH-1:0]    ch_bcd
);

    // R1: the control address never returns data
    a_r1_ctl_read_zero: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && bus_addr == 2'd3) |-> (bus_rdata == 8'h00));

    // R3: at most one channel reloads per cycle
    a_r3_one_load: assert property (@(posedge clk) disable iff (rst)
        $onehot0(ld_stb));

    // R3: a reload follows a data-port write
    a_r3_load_after_wr: assert property (@(posedge clk) disable iff (rst)
        (|ld_stb) |-> $past(bus_wr && bus_addr != 2'd3));

    // R2: configuration moves only on a control write
    a_r2_cfg_hold: assert property (@(posedge clk) disable iff (rst)
        !(bus_wr && bus_addr == 2'd3) |=> $stable({ch_mode, ch_acc, ch_bcd}));

endmodule

bind tmr_host_if tmr_host_if_chk #(.NCH(NCH)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_rdata (bus_rdata),
    .ld_stb    (ld_stb),
    .ch_mode   (ch_mode),
    .ch_acc    (ch_acc),
    .ch_bcd    (ch_bcd)
);

// File: tb/sim_tmr_host_if.sv
module sim_tmr_host_if;
    timeunit 1ns;
    timeprecision 100ps;

    localparam int NCH = 3;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [1:0]        bus_addr = '0;
    logic              bus_wr = 1'b0;
    logic              bus_rd = 1'b0;
    logic [7:0]        bus_wdata = '0;
    logic [7:0]        bus_rdata;
    logic [NCH-1:0]    ld_stb;
    logic [NCH*16-1:0] ld_val;
    logic [NCH*3-1:0]  ch_mode;
    logic [NCH*2-1:0]  ch_acc;
    logic [NCH-1:0]    ch_bcd;
    logic [NCH*16-1:0] cnt_live = '0;
    logic [NCH-1:0]    out_lvl = '0;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    typedef struct {
        logic [7:0] v;
        string      tag;
    } rd_item_t;

    typedef struct {
        int          ch;
        logic [15:0] v;
        string       tag;
    } ld_item_t;

    rd_item_t rd_q[$];
    ld_item_t ld_q[$];

    always #2.5 clk = ~clk;

    tmr_host_if #(.NCH(NCH)) u0 (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .ld_stb(ld_stb), .ld_val(ld_val), .ch_mode(ch_mode), .ch_acc(ch_acc),
        .ch_bcd(ch_bcd), .cnt_live(cnt_live), .out_lvl(out_lvl)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Monitor: compare read data and reloads against queued expectations.
    always @(negedge clk) begin
        if (!rst) begin
            if (bus_rd) begin
                if (rd_q.size() == 0) begin
                    check(1'b0, "unexpected read", {24'h0, bus_rdata}, 32'h0);
                end else begin
                    rd_item_t it;
                    it = rd_q.pop_front();
                    check(bus_rdata == it.v, it.tag, {24'h0, bus_rdata}, {24'h0, it.v});
                end
            end
            for (int c = 0; c < NCH; c++) begin
                if (ld_stb[c]) begin
                    if (ld_q.size() == 0) begin
                        check(1'b0, "unexpected load", {c[15:0], ld_val[c*16 +: 16]}, 32'h0);
                    end else begin
                        ld_item_t li;
                        li = ld_q.pop_front();
                        check(li.ch == c && ld_val[c*16 +: 16] == li.v, li.tag,
                              {c[15:0], ld_val[c*16 +: 16]}, {li.ch[15:0], li.v});
                    end
                end
            end
        end
    end

    task automatic rd(input logic [1:0] a, input logic [7:0] exp, input string tag);
        rd_item_t it;
        it.v = exp; it.tag = tag;
        rd_q.push_back(it);
        bus_addr = a; bus_rd = 1'b1;
        @(posedge clk); #1;
        bus_rd = 1'b0;
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(posedge clk); #1;
        bus_wr = 1'b0;
    endtask

    task automatic wr_ld(input logic [1:0] a, input logic [7:0] d, input int ch,
                         input logic [15:0] v, input string tag);
        ld_item_t li;
        li.ch = ch; li.v = v; li.tag = tag;
        ld_q.push_back(li);
        wr(a, d);
    endtask

    task automatic set_live(input int ch, input logic [15:0] v);
        cnt_live[ch*16 +: 16] = v;
    endtask

    initial begin
        #400000;
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        // R12: reset state
        check(ld_stb == '0, "R12 no load after reset", {29'h0, ld_stb}, 32'h0);
        check({ch_mode, ch_acc, ch_bcd} == '0, "R12 cfg zero after reset",
              {14'h0, ch_mode, ch_acc, ch_bcd}, 32'h0);
        @(posedge clk); #1;

        set_live(0, 16'h1234);
        rd(2'd0, 8'h34, "R12 access 0 reads low byte");
        wr_ld(2'd0, 8'h56, 0, 16'h0056, "R12 access 0 writes low byte");
        rd(2'd3, 8'h00, "R1 control port reads zero");

        // R2: configure channel 1 as word, mode 2, decimal
        wr(2'd3, 8'h75);
        @(negedge clk);
        check(ch_acc == 6'b001100, "R2 access fields", {26'h0, ch_acc}, 32'b001100);
        check(ch_mode == 9'b000_010_000, "R2 mode fields", {23'h0, ch_mode}, 32'b000010000);
        check(ch_bcd == 3'b010, "R2 decimal fields", {29'h0, ch_bcd}, 32'b010);
        @(posedge clk); #1;

        // R4: word write
        wr(2'd1, 8'hAB);
        wr_ld(2'd1, 8'hCD, 1, 16'hCDAB, "R4 word load");

        // R3: high only on ch2, low only on ch0
        wr(2'd3, 8'hA0);
        wr_ld(2'd2, 8'h7E, 2, 16'h7E00, "R3 high-only load");
        wr(2'd3, 8'h16);
        wr_ld(2'd0, 8'h99, 0, 16'h0099, "R3 low-only load");

        // R5: control word restarts the write sequencer
        wr(2'd1, 8'h11);
        wr(2'd3, 8'h75);
        wr(2'd1, 8'h22);
        wr_ld(2'd1, 8'h33, 1, 16'h3322, "R5 sequencer restart");

        // R10: unlatched reads
        set_live(1, 16'hBEEF);
        rd(2'd1, 8'hEF, "R10 word read low");
        rd(2'd1, 8'hBE, "R10 word read high");
        rd(2'd1, 8'hEF, "R10 word read low again");
        set_live(2, 16'h4321);
        rd(2'd2, 8'h43, "R10 high-only read");
        rd(2'd2, 8'h43, "R10 high-only read repeat");
        rd(2'd0, 8'h34, "R10 low-only read");

        // R11 and R5: independent sequencers
        wr(2'd3, 8'h75);
        rd(2'd1, 8'hEF, "R5 read sequencer restart");
        wr(2'd1, 8'h55);
        rd(2'd2, 8'h43, "R11 other channel read");
        rd(2'd1, 8'hBE, "R11 read toggle unaffected by write");
        wr_ld(2'd1, 8'h66, 1, 16'h6655, "R11 write toggle unaffected by read");

        // R6: counter latch in word access
        set_live(1, 16'h1357);
        wr(2'd3, 8'h40);
        set_live(1, 16'h2468);
        rd(2'd1, 8'h57, "R6 latched low");
        rd(2'd1, 8'h13, "R6 latched high");
        rd(2'd1, 8'h68, "R6 released live low");
        rd(2'd1, 8'h24, "R6 released live high");

        // R7: second count latch ignored
        set_live(1, 16'hA1B2);
        wr(2'd3, 8'h40);
        set_live(1, 16'hC3D4);
        wr(2'd3, 8'h40);
        rd(2'd1, 8'hB2, "R7 first snapshot low");
        rd(2'd1, 8'hA1, "R7 first snapshot high");
        rd(2'd1, 8'hD4, "R7 live low after release");
        rd(2'd1, 8'hC3, "R7 live high after release");

        // R8 and R9: read-back of ch0 and ch2, count and status
        out_lvl = 3'b001;
        set_live(0, 16'h0F0E);
        set_live(2, 16'h5A5A);
        set_live(1, 16'h7788);
        wr(2'd3, 8'hCA);
        set_live(0, 16'h1DE0);
        set_live(2, 16'h6B6B);
        rd(2'd0, 8'h96, "R9 status first ch0");
        rd(2'd0, 8'h0E, "R9 snapshot second ch0");
        rd(2'd0, 8'hE0, "R9 live third ch0");
        rd(2'd2, 8'h20, "R8 status byte ch2");
        rd(2'd2, 8'h5A, "R8 snapshot ch2");
        rd(2'd2, 8'h6B, "R8 live ch2");
        rd(2'd1, 8'h88, "R8 unselected channel untouched");

        // R7: second status latch ignored
        out_lvl = 3'b000;
        wr(2'd3, 8'hE8);
        out_lvl = 3'b100;
        wr(2'd3, 8'hE8);
        rd(2'd2, 8'h20, "R7 first status kept");
        rd(2'd2, 8'h6B, "R7 status released");

        repeat (3) @(posedge clk);
        check(rd_q.size() == 0 && ld_q.size() == 0, "R3 all expected items seen",
              rd_q.size() + ld_q.size(), 0);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule